// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is a synthesizable stand-in for a parallel NOR flash that is driven by command writes rather than by plain stores. The host has single-cycle read and write strobes, a byte address and a data word of 8, 16 or 32 bits. In the idle state the low byte of a write is taken as a command code. Some codes change the read mode at once. Others open a sequence of two to four write cycles, such as program, sector erase, buffered write or lock. The command that is currently held decides what a read returns: array contents, the status byte, identification codes or a fixed query table.

The storage is a small internal array made of whole words. A sector erase runs in the background. It fills one word per clock with all ones, keeps the ready bit (status bit 7) low until it finishes, and drops any writes that arrive while it runs. A configuration input selects big- or little-endian lane order for multi-byte data. A parameter selects read data that is either registered one cycle after the read strobe or combinational.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset the block is in array-read mode with status 0x00, so a status read straight after reset returns 0.
- R2: Command 0x10 or 0x40 arms a program. The next write stores its data word at the word address, sets status bit 7 and returns to idle. Reads then return status until 0xFF is written.
- R3: Command 0x20 erases the sector that holds the address. The address is aligned down to SECTOR_WORDS words, and the erase writes all-ones one word per clock. Other sectors keep their contents. Status bit 7 reads 0 while the erase runs and 1 after it ends.
- R4: Writes that arrive while an erase is running change nothing: the mode and the sequence state stay as they were.
- R5: After an erase, 0xD0 completes it and reads keep returning status. 0xFF returns to array read. Any other value is an error and returns to array read.
- R6: Command 0xE8 starts a buffered write. The next write gives a count N. The next N+1 writes store data and set status bit 7. After them, 0xD0 returns to idle with reads returning status. Any other value at that point returns to array read.
- R7: Command 0x60 followed by 0xD0 or 0x01 sets status bit 7 and returns to idle, with reads returning status. Any other second value returns to array read.
- R8: 0x50 clears the whole status byte and selects array read. 0xFF, 0x00 and any unknown command in idle also select array read.
- R9: 0x70 makes reads return the status byte, zero-extended. 0x90 makes reads return the manufacturer code at word offset 0, the device code at offset 1, and 0 at any other offset. Neither command opens a further write cycle.
- R10: For identification and query reads, the word offset is the low address byte shifted right by log2(bytes per word). For the default 16-bit word that shift is 1.
- R11: 0x98 enters query mode. Reads return table bytes: 0x51, 0x52, 0x59 at offsets 0x10 to 0x12; log2(total bytes) at 0x27; log2(buffer bytes) at 0x2A; 0x01 at 0x2C; sectors-1 at 0x2D and 0x2E (low byte, then high byte); 0x50 at 0x31. Any offset of 0x40 or more returns 0. Writes other than 0xFF keep query mode; 0xFF leaves it.
- R12: Data bytes sit in the array in address order. With big_endian low, the byte at the lowest address is the least significant lane. With big_endian high, it is the most significant lane. A word written in one order and read in the other therefore comes back byte-reversed.
- R13: With REG_RD=1, rdata takes its new value at the clock edge where rd_en is high and holds it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data; low byte is the command code |
| big_endian | input | 1 | Lane order for data words |
| rdata | output | DATA_W | Read result for the current mode |

## Verification
The hardest situation to reach is a write that lands while a sector erase is still running. The host has no way to see the erase counter, so the stimulus sends an erase and then, within the sector-length window, issues a read-array command and a status read. Both must show the erase still in progress. After a wait longer than the sector, the ready bit and a full sweep of the array show that the erase touched exactly one sector and that the stray write left no trace. Query and identification modes are swept over every low address byte, which exercises the offset scaling and the zero returned beyond the table.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ARG     = 2'd1,
    CYC_DATA    = 2'd2,
    CYC_CONFIRM = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_IDENT  = 2'd2,
    RS_TABLE  = 2'd3
  } rsel_e;

  localparam logic [7:0] OP_NULL   = 8'h00;
  localparam logic [7:0] OP_UNLK   = 8'h01;
  localparam logic [7:0] OP_PROG_A = 8'h10;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_PROG_B = 8'h40;
  localparam logic [7:0] OP_CLEAR  = 8'h50;
  localparam logic [7:0] OP_LOCK   = 8'h60;
  localparam logic [7:0] OP_STAT   = 8'h70;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_TABLE  = 8'h98;
  localparam logic [7:0] OP_GO     = 8'hD0;
  localparam logic [7:0] OP_BURST  = 8'hE8;
  localparam logic [7:0] OP_ARRAY  = 8'hFF;

  localparam int TABLE_LEN = 64;
endpackage

// File: rtl/fcs_erase.sv
module fcs_erase #(
  parameter int IDX_W = 6,
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] at_idx,
  output logic             busy,
  output logic             done,
  output logic             we,
  output logic [IDX_W-1:0] widx
);
  localparam int SEL_W = IDX_W - SEC_W;

  logic [SEL_W-1:0] sec_q;
  logic [SEC_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sec_q  <= '0;
      step_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      sec_q  <= at_idx[IDX_W-1:SEC_W];
      step_q <= '0;
    end else if (busy) begin
      step_q <= step_q + 1'b1;
      if (step_q == {SEC_W{1'b1}}) busy <= 1'b0;
    end
  end

  assign we   = busy;
  assign widx = {sec_q, step_q};
  assign done = busy && (step_q == {SEC_W{1'b1}});
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  input  logic       erase_busy,
  input  logic       erase_done,
  output cyc_e       cyc,
  output logic [7:0] cmd,
  output logic [7:0] status,
  output logic       data_we,
  output logic       erase_start
);
  logic [CNT_W-1:0] left_q;
  logic             take;
  logic             is_prog;

  assign take    = wr_en && !erase_busy;
  assign is_prog = (cmd == OP_PROG_A) || (cmd == OP_PROG_B);

  always_comb begin
    data_we     = 1'b0;
    erase_start = 1'b0;
    if (take) begin
      case (cyc)
        CYC_IDLE: erase_start = (wbyte == OP_ERASE);
        CYC_ARG:  data_we     = is_prog;
        CYC_DATA: data_we     = (cmd == OP_BURST);
        default:  data_we     = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= CYC_IDLE;
      cmd    <= OP_NULL;
      status <= 8'h00;
      left_q <= '0;
    end else begin
      if (erase_done) status[7] <= 1'b1;
      if (take) begin
        case (cyc)
          CYC_IDLE: begin
            case (wbyte)
              OP_PROG_A, OP_PROG_B, OP_LOCK, OP_TABLE: begin
                cyc <= CYC_ARG;
                cmd <= wbyte;
              end
              OP_ERASE: begin
                cyc       <= CYC_ARG;
                cmd       <= wbyte;
                status[7] <= 1'b0;
              end
              OP_BURST: begin
                cyc       <= CYC_ARG;
                cmd       <= wbyte;
                status[7] <= 1'b1;
              end
              OP_STAT, OP_IDENT: cmd <= wbyte;
              OP_CLEAR: begin
                status <= 8'h00;
                cmd    <= OP_NULL;
              end
              default: cmd <= OP_NULL;
            endcase
          end
          CYC_ARG: begin
            case (cmd)
              OP_PROG_A, OP_PROG_B: begin
                status[7] <= 1'b1;
                cyc       <= CYC_IDLE;
              end
              OP_ERASE: begin
                cyc <= CYC_IDLE;
                if (wbyte != OP_GO) cmd <= OP_NULL;
              end
              OP_BURST: begin
                left_q <= wbyte[CNT_W-1:0];
                cyc    <= CYC_DATA;
              end
              OP_LOCK: begin
                cyc <= CYC_IDLE;
                if (wbyte == OP_GO || wbyte == OP_UNLK) status[7] <= 1'b1;
                else cmd <= OP_NULL;
              end
              OP_TABLE: begin
                if (wbyte == OP_ARRAY) begin
                  cyc <= CYC_IDLE;
                  cmd <= OP_NULL;
                end
              end
              default: begin
                cyc <= CYC_IDLE;
                cmd <= OP_NULL;
              end
            endcase
          end
          CYC_DATA: begin
            if (cmd == OP_BURST) begin
              status[7] <= 1'b1;
              left_q    <= left_q - 1'b1;
              if (left_q == '0) cyc <= CYC_CONFIRM;
            end else begin
              cyc <= CYC_IDLE;
              cmd <= OP_NULL;
            end
          end
          default: begin
            cyc <= CYC_IDLE;
            if (cmd == OP_BURST && wbyte == OP_GO) status[7] <= 1'b1;
            else cmd <= OP_NULL;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter bit REG_RD = 1'b1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  generate
    if (REG_RD) begin : g_sync
      always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[ridx];
      end
    end else begin : g_async
      assign rdata = mem[ridx];
    end
  endgenerate
endmodule

// File: rtl/fcs_query_rom.sv
module fcs_query_rom
  import fcs_pkg::*;
#(
  parameter int TOTAL_BYTES  = 128,
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_BYTES = 32,
  parameter int BUF_BYTES    = 32
) (
  input  logic [7:0] off,
  output logic [7:0] val
);
  localparam int LAST_SEC = NUM_SECTORS - 1;

  always_comb begin
    val = 8'h00;
    if (int'(off) < TABLE_LEN) begin
      case (off)
        8'h10: val = 8'h51;
        8'h11: val = 8'h52;
        8'h12: val = 8'h59;
        8'h13: val = 8'h01;
        8'h15: val = 8'h31;
        8'h1B: val = 8'h45;
        8'h1C: val = 8'h55;
        8'h1F: val = 8'h07;
        8'h20: val = 8'h07;
        8'h21: val = 8'h0A;
        8'h23: val = 8'h04;
        8'h24: val = 8'h04;
        8'h25: val = 8'h04;
        8'h27: val = 8'($clog2(TOTAL_BYTES));
        8'h28: val = 8'h02;
        8'h2A: val = 8'($clog2(BUF_BYTES));
        8'h2C: val = 8'h01;
        8'h2D: val = 8'(LAST_SEC);
        8'h2E: val = 8'(LAST_SEC >> 8);
        8'h2F: val = 8'(SECTOR_BYTES >> 8);
        8'h30: val = 8'(SECTOR_BYTES >> 16);
        8'h31: val = 8'h50;
        8'h32: val = 8'h52;
        8'h33: val = 8'h49;
        8'h34: val = 8'h31;
        8'h35: val = 8'h31;
        default: val = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          SECTOR_WORDS = 16,
  parameter int          NUM_SECTORS  = 4,
  parameter int          CNT_W        = 4,
  parameter int          ADDR_W       = 8,
  parameter bit          REG_RD       = 1'b1,
  parameter logic [15:0] MFR_CODE     = 16'h00C2,
  parameter logic [15:0] DEV_CODE     = 16'h22A7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              big_endian,
  output logic [DATA_W-1:0] rdata
);
  localparam int BYTES   = DATA_W / 8;
  localparam int LANE_SH = $clog2(BYTES);
  localparam int WORDS   = SECTOR_WORDS * NUM_SECTORS;
  localparam int IDX_W   = $clog2(WORDS);
  localparam int SEC_W   = $clog2(SECTOR_WORDS);
  localparam int TOTAL_B = WORDS * BYTES;
  localparam int BUF_B   = (2 ** CNT_W) * BYTES;

  function automatic logic [DATA_W-1:0] lane_flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BYTES; b++) r[8*b +: 8] = v[8*(BYTES-1-b) +: 8];
    return r;
  endfunction

  logic [IDX_W-1:0]  word_idx;
  logic [7:0]        woff;
  logic [DATA_W-1:0] wdata_mem;

  assign word_idx  = addr[LANE_SH +: IDX_W];
  assign woff      = addr[7:0] >> LANE_SH;
  assign wdata_mem = big_endian ? lane_flip(wdata) : wdata;

  cyc_e             seq_cyc;
  logic [7:0]       seq_cmd;
  logic [7:0]       seq_status;
  logic             seq_data_we;
  logic             seq_erase_go;
  logic             er_busy;
  logic             er_done;
  logic             er_we;
  logic [IDX_W-1:0] er_idx;

  fcs_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wbyte(wdata[7:0]),
    .erase_busy(er_busy), .erase_done(er_done),
    .cyc(seq_cyc), .cmd(seq_cmd), .status(seq_status),
    .data_we(seq_data_we), .erase_start(seq_erase_go)
  );

  fcs_erase #(.IDX_W(IDX_W), .SEC_W(SEC_W)) u_erase (
    .clk(clk), .rst(rst), .start(seq_erase_go), .at_idx(word_idx),
    .busy(er_busy), .done(er_done), .we(er_we), .widx(er_idx)
  );

  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_q;

  assign mem_we    = er_we | seq_data_we;
  assign mem_widx  = er_we ? er_idx : word_idx;
  assign mem_wdata = er_we ? {DATA_W{1'b1}} : wdata_mem;

  fcs_array #(.DATA_W(DATA_W), .DEPTH(WORDS), .IDX_W(IDX_W), .REG_RD(REG_RD)) u_mem (
    .clk(clk), .we(mem_we), .widx(mem_widx), .wdata(mem_wdata),
    .rd_en(rd_en), .ridx(word_idx), .rdata(mem_q)
  );

  logic [7:0] tab_byte;

  fcs_query_rom #(
    .TOTAL_BYTES(TOTAL_B), .NUM_SECTORS(NUM_SECTORS),
    .SECTOR_BYTES(SECTOR_WORDS * BYTES), .BUF_BYTES(BUF_B)
  ) u_rom (.off(woff), .val(tab_byte));

  rsel_e             rsel;
  logic [DATA_W-1:0] side_val;

  always_comb begin
    case (seq_cmd)
      OP_NULL:  rsel = RS_ARRAY;
      OP_IDENT: rsel = RS_IDENT;
      OP_TABLE: rsel = RS_TABLE;
      default:  rsel = RS_STATUS;
    endcase
    case (rsel)
      RS_STATUS: side_val = DATA_W'(seq_status);
      RS_IDENT: begin
        if (woff == 8'd0)      side_val = DATA_W'(MFR_CODE);
        else if (woff == 8'd1) side_val = DATA_W'(DEV_CODE);
        else                   side_val = '0;
      end
      RS_TABLE: side_val = DATA_W'(tab_byte);
      default:  side_val = '0;
    endcase
  end

  generate
    if (REG_RD) begin : g_rq
      logic              arr_q;
      logic              be_q;
      logic [DATA_W-1:0] side_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          arr_q  <= 1'b0;
          be_q   <= 1'b0;
          side_q <= '0;
        end else if (rd_en) begin
          arr_q  <= (rsel == RS_ARRAY);
          be_q   <= big_endian;
          side_q <= side_val;
        end
      end
      assign rdata = arr_q ? (be_q ? lane_flip(mem_q) : mem_q) : side_q;
    end else begin : g_rc
      assign rdata = (rsel == RS_ARRAY) ? (big_endian ? lane_flip(mem_q) : mem_q) : side_val;
    end
  endgenerate
endmodule

// File: rtl/fcs_check.sv
module fcs_check (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wbyte,
  input logic       busy,
  input logic [1:0] cyc,
  input logic [7:0] cmd,
  input logic [7:0] status
);
  assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !status[7]);

  assert_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> ($stable(cmd) && $stable(cyc)));

  assert_program_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && cyc == 2'd1 && (cmd == 8'h10 || cmd == 8'h40))
      |=> (status[7] && cyc == 2'd0));

  assert_confirm_only_burst_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (cmd == 8'hE8));

  assert_lock_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && cyc == 2'd1 && cmd == 8'h60 && (wbyte == 8'hD0 || wbyte == 8'h01))
      |=> (status[7] && cyc == 2'd0 && cmd == 8'h60));

  assert_clear_status_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && cyc == 2'd0 && wbyte == 8'h50)
      |=> (status == 8'h00 && cmd == 8'h00 && cyc == 2'd0));
endmodule

bind flash_cmd_seq fcs_check u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wbyte(wdata[7:0]), .busy(er_busy),
  .cyc(seq_cyc), .cmd(seq_cmd), .status(seq_status)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int NS = 4;
  localparam int NW = SW * NS;
  localparam logic [15:0] MFR = 16'h00C2;
  localparam logic [15:0] DEV = 16'h22A7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        big_endian = 1'b0;
  logic [15:0] rdata;

  int total = 0;
  int bad = 0;
  logic [15:0] m [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(
    .DATA_W(16), .SECTOR_WORDS(SW), .NUM_SECTORS(NS), .CNT_W(4), .ADDR_W(8),
    .REG_RD(1'b1), .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .big_endian(big_endian), .rdata(rdata)
  );

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input int a, input logic [15:0] exp);
    logic [15:0] got;
    @(negedge clk);
    rd_en = 1'b1; addr = 8'(a);
    @(negedge clk);
    rd_en = 1'b0;
    got = rdata;
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%02h got=%04h exp=%04h", req, a, got, exp);
    end
  endtask

  task automatic wait_erase();
    repeat (SW + 3) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  function automatic int qexp(input int o);
    if (o >= 64) return 0;
    case (o)
      16'h10: return 8'h51;
      16'h11: return 8'h52;
      16'h12: return 8'h59;
      16'h27: return 7;
      16'h2A: return 5;
      16'h2C: return 1;
      16'h2D: return NS - 1;
      16'h2E: return 0;
      16'h31: return 8'h50;
      default: return -1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: status after reset
    wr(0, 16'h0070);
    chk("R1", 0, 16'h0000);
    wr(0, 16'h00FF);

    // R3: erase every sector, busy status on the first
    for (int s = 0; s < NS; s++) begin
      wr(s * SW * 2, 16'h0020);
      if (s == 0) chk("R3", 0, 16'h0000);
      wait_erase();
      if (s == 0) chk("R3", 0, 16'h0080);
      wr(0, 16'h00D0);
    end
    wr(0, 16'h00FF);
    for (int i = 0; i < NW; i++) begin
      m[i] = 16'hFFFF;
      chk("R3", 2 * i, 16'hFFFF);
    end

    // R2: program every word, alternating both program codes
    for (int i = 0; i < NW; i++) begin
      wr(2 * i, (i % 2 == 0) ? 16'h0040 : 16'h0010);
      wr(2 * i, pat(i));
      m[i] = pat(i);
      if (i < 2) chk("R2", 2 * i, 16'h0080);
    end
    wr(0, 16'h00FF);
    for (int i = 0; i < NW; i++) chk("R2", 2 * i, m[i]);

    // R4/R5: erase sector 2 via a mid-sector address, write during busy
    wr(2 * 37, 16'h0020);
    wr(0, 16'h00FF);
    chk("R4", 0, 16'h0000);
    wait_erase();
    chk("R4", 0, 16'h0080);
    wr(0, 16'h00D0);
    chk("R5", 0, 16'h0080);
    wr(0, 16'h00FF);
    for (int i = 32; i < 48; i++) m[i] = 16'hFFFF;
    for (int i = 0; i < NW; i++) chk("R3", 2 * i, m[i]);

    // R5: 0xFF after erase, and an error value after erase
    wr(2 * 50, 16'h0020);
    wait_erase();
    wr(0, 16'h00FF);
    for (int i = 48; i < 64; i++) m[i] = 16'hFFFF;
    chk("R5", 2 * 50, 16'hFFFF);
    wr(0, 16'h0020);
    wait_erase();
    wr(0, 16'h0033);
    for (int i = 0; i < 16; i++) m[i] = 16'hFFFF;
    chk("R5", 2 * 3, 16'hFFFF);
    chk("R5", 2 * 16, m[16]);

    // R6: buffered write of four words, then a bad confirm
    wr(8, 16'h00E8);
    wr(8, 16'h0003);
    for (int k = 0; k < 4; k++) begin
      wr(2 * (4 + k), 16'hC000 + 16'(k));
      m[4 + k] = 16'hC000 + 16'(k);
    end
    wr(8, 16'h00D0);
    chk("R6", 8, 16'h0080);
    wr(0, 16'h00FF);
    for (int k = 0; k < 4; k++) chk("R6", 2 * (4 + k), m[4 + k]);
    wr(40, 16'h00E8);
    wr(40, 16'h0000);
    wr(40, 16'hBEEF);
    m[20] = 16'hBEEF;
    wr(40, 16'h0055);
    chk("R6", 40, 16'hBEEF);

    // R7/R8: clear, lock acknowledge, lock abort
    wr(0, 16'h0050);
    wr(0, 16'h0070);
    chk("R8", 0, 16'h0000);
    wr(0, 16'h0060);
    wr(0, 16'h00D0);
    chk("R7", 0, 16'h0080);
    wr(0, 16'h0050);
    wr(0, 16'h0060);
    wr(0, 16'h0001);
    chk("R7", 0, 16'h0080);
    wr(0, 16'h0060);
    wr(0, 16'h0077);
    chk("R7", 2 * 4, m[4]);
    wr(0, 16'h0070);
    wr(0, 16'h0000);
    chk("R8", 2 * 5, m[5]);
    wr(0, 16'h0070);
    wr(0, 16'h00AB);
    chk("R8", 2 * 6, m[6]);
    wr(0, 16'h0070);
    wr(0, 16'h0050);
    chk("R8", 2 * 7, m[7]);

    // R9/R10: identification sweep over every low address byte
    wr(0, 16'h0090);
    for (int b = 0; b < 256; b++) begin
      int o;
      o = b >> 1;
      chk("R10", b, (o == 0) ? MFR : (o == 1) ? DEV : 16'h0000);
    end
    wr(0, 16'h0070);
    chk("R9", 0, 16'h0000);
    wr(0, 16'h00FF);

    // R11: query sweep, stay on other writes, leave on 0xFF
    wr(0, 16'h0098);
    for (int b = 0; b < 256; b++) begin
      int e;
      e = qexp(b >> 1);
      if (e >= 0) chk("R11", b, 16'(e));
    end
    wr(0, 16'h0012);
    chk("R11", 8'h20, 16'h0051);
    wr(0, 16'h00FF);
    chk("R11", 2 * 8, m[8]);

    // R12: lane order
    big_endian = 1'b1;
    wr(2 * 10, 16'h0040);
    wr(2 * 10, 16'h1234);
    wr(0, 16'h00FF);
    chk("R12", 2 * 10, 16'h1234);
    big_endian = 1'b0;
    chk("R12", 2 * 10, 16'h3412);

    // R13: read result holds without a strobe
    chk("R13", 2 * 21, m[21]);
    @(negedge clk);
    addr = 8'(2 * 22);
    repeat (2) @(negedge clk);
    total++;
    if (rdata !== m[21]) begin
      bad++;
      $display("FAIL R13 hold got=%04h exp=%04h", rdata, m[21]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule